// File: doc/BRIEF.md
# Table-driven Mealy state machine

This block is a synchronous Mealy machine with a single-bit input. Two elaboration-time tables set its behaviour. One holds the successor state and the other holds the output bit. Both tables are addressed by the pair (current state, input bit). Because the machine is built from lookups rather than hand-written branches, one piece of RTL can serve any small serial recogniser once the tables are filled in.

With the default tables, the block recognises the serial pattern 1011 in an incoming bit stream, and matches may overlap. The default state encoding is:

- 0: idle, no progress yet.
- 1: a "1" has been seen.
- 2: "10" has been seen.
- 3: "101" has been seen.

The upstream source marks each bit it presents with a valid strobe. The machine advances only on strobed bits. Its output is a Mealy flag that comes combinationally from the current state and the present bit.

Top module: `tbl_mealy_fsm`

## Requirements
- R1: On a rising edge with `bit_vld` high and `rst` low, `state_o` takes the next-state table entry for (state, `bit_in`). With the default tables the successors are: from 0, bit 0 gives 0 and bit 1 gives 1; from 1, bit 0 gives 2 and bit 1 gives 1; from 2, bit 0 gives 0 and bit 1 gives 3; from 3, bit 0 gives 2 and bit 1 gives 1.
- R2: `match_o` is the output table entry for the present state and the present `bit_in`, in the same cycle. With the default tables it is 1 only in state 3 with input 1, which is the cycle that carries the final 1 of 1011.
- R3: While `bit_vld` is low, `state_o` keeps its value.
- R4: With `rst` high at a rising edge, `state_o` becomes 0 on that edge, whatever `bit_vld` and `bit_in` are.
- R5: While `bit_vld` is low, `match_o` is 0.
- R6: A state value of `N_STATES` or above drives `match_o` to 0. On the next strobed edge it moves the machine to state 0.
- R7: Detection overlaps. After a match the machine is in state 1, so the stream 1011011 gives two matches, on its 4th and 7th bits.
- R8: Both tables are flat packed vectors in which entry e = 2·state + bit.
  - The next state for entry e is `NEXT_TBL[e*ST_W +: ST_W]`.
  - The output bit for entry e is `OUT_TBL[e]`.
  - Any entry can point to any state code, including codes of `N_STATES` or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe marking `bit_in` as a real sample |
| bit_in | input | 1 | Serial input bit |
| state_o | output | ST_W | Registered current state |
| match_o | output | 1 | Mealy output from the output table |

## Verification
A wrong successor entry or a stuck state register shows up on `state_o` at the first strobed edge after the faulty lookup. A wrong output entry shows up on `match_o` in the same cycle as the bit that selects it. An error in the state usually also breaks pattern tracking, so `match_o` either misses the next 1011 or flags a match that the sliding 4-bit window reference does not expect. Checking `state_o` on every step catches errors that would otherwise stay hidden until the next pattern arrives.

// File: rtl/mealy_pkg.sv
package mealy_pkg;
  // number of columns per table row (input bit values)
  localparam int IN_VALS = 2;
endpackage

// File: rtl/mealy_next_lut.sv
module mealy_next_lut #(
  parameter int N_STATES = 4,
  parameter int ST_W     = 2,
  parameter logic [N_STATES*mealy_pkg::IN_VALS*ST_W-1:0] NEXT_TBL = '0
) (
  input  logic [ST_W-1:0] state_i,
  input  logic            din_i,
  output logic [ST_W-1:0] next_o
);
  localparam int N_ENT = N_STATES * mealy_pkg::IN_VALS;
  localparam int SLOTS = 2 ** (ST_W + 1);

  // Table padded to every encodable (state, bit) pair; spare slots go to 0
  logic [ST_W-1:0] slot [SLOTS];

  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    if (e < N_ENT) begin : g_used
      assign slot[e] = NEXT_TBL[e*ST_W +: ST_W];
    end else begin : g_spare
      assign slot[e] = '0;
    end
  end

  assign next_o = slot[{state_i, din_i}];
endmodule

// File: rtl/mealy_out_lut.sv
module mealy_out_lut #(
  parameter int N_STATES = 4,
  parameter int ST_W     = 2,
  parameter logic [N_STATES*mealy_pkg::IN_VALS-1:0] OUT_TBL = '0
) (
  input  logic [ST_W-1:0] state_i,
  input  logic            din_i,
  input  logic            valid_i,
  output logic            out_o
);
  localparam int N_ENT = N_STATES * mealy_pkg::IN_VALS;
  localparam int SLOTS = 2 ** (ST_W + 1);

  logic slot [SLOTS];

  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    if (e < N_ENT) begin : g_used
      assign slot[e] = OUT_TBL[e];
    end else begin : g_spare
      assign slot[e] = 1'b0;
    end
  end

  assign out_o = valid_i & slot[{state_i, din_i}];
endmodule

// File: rtl/mealy_state_reg.sv
module mealy_state_reg #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [ST_W-1:0] next_i,
  output logic [ST_W-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (rst)          state_q <= '0;
    else if (valid_i) state_q <= next_i;
  end

  // R3
  hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(state_q));

  // R4
  reset_to_zero_chk: assert property (@(posedge clk)
    rst |=> (state_q == '0));

  // R1
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (state_q == $past(next_i)));
endmodule

// File: rtl/tbl_mealy_fsm.sv
module tbl_mealy_fsm #(
  parameter int N_STATES = 4,
  parameter int ST_W     = 2,
  // default: overlapping 1011 recogniser, entry e = 2*state + bit
  parameter logic [N_STATES*mealy_pkg::IN_VALS*ST_W-1:0] NEXT_TBL = 16'h6C64,
  parameter logic [N_STATES*mealy_pkg::IN_VALS-1:0]      OUT_TBL  = 8'h80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_vld,
  input  logic            bit_in,
  output logic [ST_W-1:0] state_o,
  output logic            match_o
);
  localparam bit HAS_SPARE = (2 ** ST_W) > N_STATES;

  logic [ST_W-1:0] nxt;

  mealy_next_lut #(.N_STATES(N_STATES), .ST_W(ST_W), .NEXT_TBL(NEXT_TBL)) u_next (
    .state_i(state_o), .din_i(bit_in), .next_o(nxt)
  );

  mealy_out_lut #(.N_STATES(N_STATES), .ST_W(ST_W), .OUT_TBL(OUT_TBL)) u_out (
    .state_i(state_o), .din_i(bit_in), .valid_i(bit_vld), .out_o(match_o)
  );

  mealy_state_reg #(.ST_W(ST_W)) u_state (
    .clk(clk), .rst(rst), .valid_i(bit_vld), .next_i(nxt), .state_q(state_o)
  );

  // R5
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> bit_vld);

  if (HAS_SPARE) begin : g_spare_chk
    // R6
    oob_recover_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && state_o >= ST_W'(N_STATES)) |=> (state_o == '0));
    // R6
    oob_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o >= ST_W'(N_STATES)) |-> !match_o);
  end
endmodule

// File: tb/test_tbl_mealy_fsm.sv
`timescale 1ns/1ps
module test_tbl_mealy_fsm;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, bit_vld, bit_in, match_o;
  logic [1:0] state_o;
  logic       rst2, vld2, din2, match2;
  logic [1:0] state2;

  tbl_mealy_fsm i_tbl_mealy_fsm (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .state_o(state_o), .match_o(match_o)
  );

  // three-state machine whose table points at unused code 3 (R6, R8)
  tbl_mealy_fsm #(.N_STATES(3), .ST_W(2), .NEXT_TBL(12'h0C4), .OUT_TBL(6'h3F)) i_tbl_mealy_fsm_oob (
    .clk(clk), .rst(rst2), .bit_vld(vld2), .bit_in(din2),
    .state_o(state2), .match_o(match2)
  );

  // {valid, bit}
  localparam logic [1:0] VEC [28] = '{
    2'b11, 2'b10, 2'b11, 2'b11, 2'b10, 2'b11, 2'b11,
    2'b11, 2'b10, 2'b01, 2'b11, 2'b11,
    2'b11, 2'b10, 2'b11, 2'b01, 2'b11,
    2'b10, 2'b10, 2'b11, 2'b11, 2'b10, 2'b11, 2'b11, 2'b10, 2'b11, 2'b11, 2'b11
  };

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [2:0] hist;

  function automatic logic [1:0] ref_state();
    if (hist == 3'b101)      return 2'd3;
    if (hist[1:0] == 2'b10)  return 2'd2;
    if (hist[0])             return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic d, input string tag);
    logic exp_m;
    @(negedge clk);
    check({tag, " state"}, 4'(state_o), 4'(ref_state()));
    bit_vld = v; bit_in = d;
    #1;
    exp_m = v && d && (hist == 3'b101);
    check({tag, " match"}, 4'(match_o), 4'(exp_m));
    if (v) hist = {hist[1:0], d};
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0; hist = '0;
    rst2 = 1'b1; vld2 = 1'b0; din2 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset state", 4'(state_o), 4'd0);
    check("R5 reset match", 4'(match_o), 4'd0);
    rst = 1'b0;

    // directed vector walk: overlap, idle gaps, idle at state 3
    for (int i = 0; i < 28; i++) step(VEC[i][1], VEC[i][0], "R1 R2 R3 R5 R7 vec");

    // random streams with idle cycles
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, 1'($urandom % 2), "R1 R2 R3 R5 R7 rand");

    // reset overrides a strobed bit
    step(1'b1, 1'b1, "R1 pre"); step(1'b1, 1'b0, "R1 pre"); step(1'b1, 1'b1, "R1 pre");
    @(negedge clk);
    check("R1 at state 3", 4'(state_o), 4'd3);
    rst = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    check("R4 reset with valid", 4'(state_o), 4'd0);
    rst = 1'b0; bit_vld = 1'b0; hist = '0;
    step(1'b1, 1'b1, "R4 after"); step(1'b1, 1'b0, "R4 after");

    // custom tables and out-of-range state
    @(negedge clk);
    rst2 = 1'b0;
    vld2 = 1'b1; din2 = 1'b1;
    #1 check("R8 out s0b1", 4'(match2), 4'd1);
    @(negedge clk);
    check("R8 next s0b1", 4'(state2), 4'd1);
    #1 check("R8 out s1b1", 4'(match2), 4'd1);
    @(negedge clk);
    check("R8 next to code 3", 4'(state2), 4'd3);
    vld2 = 1'b0;
    #1 check("R5 idle match", 4'(match2), 4'd0);
    @(negedge clk);
    check("R3 hold code 3", 4'(state2), 4'd3);
    vld2 = 1'b1; din2 = 1'b1;
    #1 check("R6 oob match", 4'(match2), 4'd0);
    @(negedge clk);
    check("R6 oob recover", 4'(state2), 4'd0);
    vld2 = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule